// File: doc/BRIEF.md
# JTAG Identification Code Reader

This block is a host-side JTAG master for a chain that holds exactly one device. On a start pulse it derives a test clock from the system clock and plays a fixed sequence of TMS values. The sequence forces the test access port into its reset state, loads a configurable instruction, walks the port into the data-shift state and clocks out a 32-bit identification word. The word is assembled with the first bit received as bit 0. When the port is back in Run-Test/Idle, the block raises a one-cycle done pulse and presents the word. A flag marks the result as suspect when every bit is one or every bit is zero, which is what an open or shorted chain returns.

The test-clock half period is worked out from the system clock rate and the highest TCK rate the chain allows. With a 50 MHz system clock and a 2 MHz ceiling, the half period is 13 system clocks. The instruction length and value are parameters. TDI carries the instruction during the IR scan and is held at one at every other time.

Top module: `jtag_idcode_reader`

## Requirements
- R1: After synchronous reset, busy, done, tck, id and id_err are all 0, and tms and tdi are both 1.
- R2: A start pulse while idle sets busy from the next clock. TCK then begins low and toggles every HALF system clocks, where HALF is ceil(SYS_CLK_HZ / (2 * TCK_MAX_HZ)) and equals 13 by default. Each TCK cycle is low first, then high.
- R3: tms and tdi change only on the system clock edge where tck falls, or on the edge where a run begins while tck is low.
- R4: The TMS values seen at the first ten TCK rising edges are 1,1,1,1,1 (reset), then 0 (idle), then 1,1,0,0, which ends in Shift-IR.
- R5: The instruction is shifted on TDI least significant bit first, one bit per rising edge. TMS is 0 for every instruction bit except the last, where it is 1. One further edge with TMS=1 reaches Update-IR.
- R6: After Update-IR, TMS is 0,1,0,0 on four edges, which ends in Shift-DR.
- R7: TDO is sampled on 32 consecutive rising edges. TMS is 0 on the first 31 of these edges and 1 on the last, which moves the port to Exit1-DR. The first sampled bit becomes id bit 0. A device that returns 0x20614093 yields id = 0x20614093.
- R8: After the last data bit, TMS is 1 then 0, which passes Update-DR and returns to Run-Test/Idle. A run lasts 49+IR_LEN TCK cycles. Done is a single-cycle pulse on the clock where busy falls, and id and id_err are valid from that same clock.
- R9: id_err is 1 after a run that returned all ones or all zeros, and 0 otherwise.
- R10: A start pulse while busy has no effect, and the run finishes at its original time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read when idle |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| id | output | 32 | Captured identification word |
| id_err | output | 1 | Result was all ones or all zeros |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
Two events share a single TCK rising edge. The 32nd identification bit is sampled on the same edge where TMS=1 moves the port out of Shift-DR, so both the exit and the final sample must land there. The bench runs a behavioural TAP in its own state machine that shifts the word out bit by bit. A correct id, together with the TAP finishing in Run-Test/Idle with the right instruction, shows that both happened on that edge. A second overlap is a start pulse that arrives in the middle of a run. The bench checks busy and tck on every clock against a timeline computed from the start edge alone, so a restart or any stretch of the run shows up as a mismatch.

// File: rtl/jtag_id_pkg.sv
package jtag_id_pkg;

    localparam int ID_W = 32;

    // per-TCK-cycle drive and sample plan
    typedef struct packed {
        logic tms;
        logic tdi;
        logic cap;
    } step_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    function automatic int script_len(int ir_len);
        return 49 + ir_len;
    endfunction

    // k: TCK cycle index, l: instruction length, code: instruction value
    function automatic step_t step_of(int k, int l, logic [31:0] code);
        step_t s;
        s.tdi = 1'b1;
        s.cap = 1'b0;
        if (k < 5)                s.tms = 1'b1;
        else if (k == 5)          s.tms = 1'b0;
        else if (k < 8)           s.tms = 1'b1;
        else if (k < 10)          s.tms = 1'b0;
        else if (k < 10 + l) begin
            s.tms = (k == 9 + l);
            s.tdi = code[k - 10];
        end
        else if (k == 10 + l)     s.tms = 1'b1;
        else if (k == 11 + l)     s.tms = 1'b0;
        else if (k == 12 + l)     s.tms = 1'b1;
        else if (k < 15 + l)      s.tms = 1'b0;
        else if (k < 47 + l) begin
            s.tms = (k == 46 + l);
            s.cap = 1'b1;
        end
        else if (k == 47 + l)     s.tms = 1'b1;
        else                      s.tms = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/tck_divider.sv
module tck_divider #(
    parameter int HALF = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // R2: half period never exceeds HALF system clocks
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(HALF));

endmodule

// File: rtl/tap_script.sv
module tap_script
    import jtag_id_pkg::*;
#(
    parameter int          IR_LEN  = 5,
    parameter logic [31:0] IR_WORD = 32'h9
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic run,
    output logic tck,
    output logic tms,
    output logic tdi,
    output logic cap_en,
    output logic finish
);
    localparam int STEPS  = script_len(IR_LEN);
    localparam int STEP_W = $clog2(STEPS);

    phase_t            phase;
    logic [STEP_W-1:0] step;
    step_t             cur, nxt;

    assign cur    = step_of(int'(step), IR_LEN, IR_WORD);
    assign nxt    = step_of(int'(step) + 1, IR_LEN, IR_WORD);
    assign run    = (phase != PH_IDLE);
    assign tck    = (phase == PH_HIGH);
    assign cap_en = (phase == PH_LOW) && tick && cur.cap;
    assign finish = (phase == PH_HIGH) && tick && (step == STEP_W'(STEPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= '0;
            tms   <= 1'b1;
            tdi   <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    step  <= '0;
                    phase <= PH_LOW;
                    tms   <= step_of(0, IR_LEN, IR_WORD).tms;
                    tdi   <= step_of(0, IR_LEN, IR_WORD).tdi;
                end
                PH_LOW: if (tick) phase <= PH_HIGH;
                PH_HIGH: if (tick) begin
                    if (finish) begin
                        phase <= PH_IDLE;
                        tms   <= 1'b1;
                        tdi   <= 1'b1;
                    end else begin
                        step  <= step + 1'b1;
                        phase <= PH_LOW;
                        tms   <= nxt.tms;
                        tdi   <= nxt.tdi;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3: TMS and TDI hold while TCK is high
    a_r3_tms_hold_high: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH) |-> ($stable(tms) && $stable(tdi)));

    // R2: a start while idle launches a run
    a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> (phase == PH_LOW));

    // R10: start during a run does not restart the script
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW && !tick && start) |=> (phase == PH_LOW && $stable(step)));

endmodule

// File: rtl/id_shifter.sv
module id_shifter
    import jtag_id_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_en,
    input  logic            tdo,
    input  logic            finish,
    output logic [ID_W-1:0] id,
    output logic            id_err,
    output logic            done
);
    logic [ID_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            id     <= '0;
            id_err <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (cap_en) sr <= {tdo, sr[ID_W-1:1]};
            if (finish) begin
                id     <= sr;
                id_err <= (sr == '0) || (&sr);
            end
        end
    end

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: nothing is sampled on the completion cycle
    a_r7_no_cap_at_finish: assert property (@(posedge clk) disable iff (rst)
        !(cap_en && finish));

endmodule

// File: rtl/jtag_idcode_reader.sv
module jtag_idcode_reader
    import jtag_id_pkg::*;
#(
    parameter int                SYS_CLK_HZ = 50_000_000,
    parameter int                TCK_MAX_HZ = 2_000_000,
    parameter int                IR_LEN     = 5,
    parameter logic [IR_LEN-1:0] IR_CODE    = 5'b01001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic [31:0] id,
    output logic        id_err,
    output logic        tck,
    output logic        tms,
    output logic        tdi,
    input  logic        tdo
);
    localparam int HALF = (SYS_CLK_HZ + 2 * TCK_MAX_HZ - 1) / (2 * TCK_MAX_HZ);

    logic run, tick, cap_en, finish;

    tck_divider #(.HALF(HALF)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    tap_script #(
        .IR_LEN  (IR_LEN),
        .IR_WORD (32'(IR_CODE))
    ) u_script (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tick   (tick),
        .run    (run),
        .tck    (tck),
        .tms    (tms),
        .tdi    (tdi),
        .cap_en (cap_en),
        .finish (finish)
    );

    id_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .tdo    (tdo),
        .finish (finish),
        .id     (id),
        .id_err (id_err),
        .done   (done)
    );

    assign busy = run;

    // R8: done coincides with busy falling
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

// File: tb/test_jtag_idcode_reader.sv
module test_jtag_idcode_reader;

    localparam int          HALF   = 13;
    localparam int          IRL    = 5;
    localparam logic [4:0]  IRC    = 5'b01001;
    localparam int          NCYC   = 49 + IRL;
    localparam int          TOT    = 2 * HALF * NCYC;
    localparam logic [31:0] DEV_ID = 32'h20614093;

    // TAP state codes (bench model)
    localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHDR = 4, E1DR = 5, PDR = 6, E2DR = 7,
                   UDR = 8, SIR = 9, CIR = 10, SHIR = 11, E1IR = 12, PIR = 13, E2IR = 14, UIR = 15;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, tdo = 1'b1;
    logic busy, done, id_err, tck, tms, tdi;
    logic [31:0] id;

    int n_chk = 0, n_fail = 0;
    int mode = 0;            // 0 device, 1 stuck high, 2 stuck low
    int tap_st = SHDR;
    logic [4:0]  ir_sr = '0, ir_q = '0;
    logic [31:0] dr_sr = '0;
    int edge_idx = 0;
    bit exp_tms[$];
    bit finished = 0;

    always #10 clk = ~clk;

    jtag_idcode_reader i_jtag_idcode_reader (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .id(id),
        .id_err(id_err), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int tap_next(int s, bit m);
        case (s)
            TLR:  return m ? TLR  : RTI;
            RTI:  return m ? SDR  : RTI;
            SDR:  return m ? SIR  : CDR;
            CDR:  return m ? E1DR : SHDR;
            SHDR: return m ? E1DR : SHDR;
            E1DR: return m ? UDR  : PDR;
            PDR:  return m ? E2DR : PDR;
            E2DR: return m ? UDR  : SHDR;
            UDR:  return m ? SDR  : RTI;
            SIR:  return m ? TLR  : CIR;
            CIR:  return m ? E1IR : SHIR;
            SHIR: return m ? E1IR : SHIR;
            E1IR: return m ? UIR  : PIR;
            PIR:  return m ? E2IR : PIR;
            E2IR: return m ? UIR  : SHIR;
            default: return m ? SDR : RTI;
        endcase
    endfunction

    // behavioural TAP plus script comparison at every TCK rise
    always @(posedge tck) begin
        if (edge_idx < NCYC) begin
            // R4 R5 R6 R7 R8: TMS script
            chk(tms == exp_tms[edge_idx], $sformatf("R4/R5/R6/R7/R8 tms@%0d", edge_idx), 32'(tms), 32'(exp_tms[edge_idx]));
            if (edge_idx >= 10 && edge_idx < 10 + IRL)
                chk(tdi == IRC[edge_idx-10], $sformatf("R5 tdi@%0d", edge_idx), 32'(tdi), 32'(IRC[edge_idx-10]));
        end
        edge_idx++;
        case (tap_st)
            TLR:  ir_q  <= IRC ^ 5'h1f;
            CIR:  ir_sr <= 5'b00001;
            SHIR: ir_sr <= {tdi, ir_sr[4:1]};
            UIR:  ir_q  <= ir_sr;
            CDR:  dr_sr <= (ir_q == IRC) ? DEV_ID : 32'h0;
            SHDR: dr_sr <= {tdi, dr_sr[31:1]};
            default: ;
        endcase
        tap_st <= tap_next(tap_st, tms);
    end

    always @(negedge tck) begin
        if (mode == 1)      tdo <= 1'b1;
        else if (mode == 2) tdo <= 1'b0;
        else if (tap_st == SHDR) tdo <= dr_sr[0];
        else if (tap_st == SHIR) tdo <= ir_sr[0];
        else                tdo <= 1'b1;
    end

    task automatic run_read(input int m, input bit poke, input logic [31:0] exp_id, input bit exp_err);
        logic p_tck, p_tms, p_tdi;
        mode = m;
        edge_idx = 0;
        @(negedge clk);
        p_tck = tck; p_tms = tms; p_tdi = tdi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= TOT; j++) begin
            // R2 R8 R10: timeline from the start edge, compared every clock
            chk(busy == (j < TOT), $sformatf("R2/R10 busy@%0d", j), 32'(busy), 32'(j < TOT));
            chk(tck == (j < TOT && ((j / HALF) % 2 == 1)), $sformatf("R2 tck@%0d", j), 32'(tck), 32'(j < TOT && ((j / HALF) % 2 == 1)));
            chk(done == (j == TOT), $sformatf("R8 done@%0d", j), 32'(done), 32'(j == TOT));
            // R3: pins move only as tck falls or at run start
            if ((tms != p_tms || tdi != p_tdi) && j != 0)
                chk(p_tck && !tck, $sformatf("R3 pin change@%0d", j), 32'(tck), 32'(0));
            p_tck = tck; p_tms = tms; p_tdi = tdi;
            if (poke && (j == 100 || j == 700)) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(done == 1'b0, "R8 done single", 32'(done), 32'(0));
        chk(id == exp_id, "R7 id", id, exp_id);
        chk(id_err == exp_err, "R9 id_err", 32'(id_err), 32'(exp_err));
        chk(edge_idx == NCYC, "R8 edge count", 32'(edge_idx), 32'(NCYC));
        if (m == 0) begin
            chk(tap_st == RTI, "R8 tap idle", 32'(tap_st), 32'(RTI));
            chk(ir_q == IRC, "R5 ir loaded", 32'(ir_q), 32'(IRC));
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 5; i++) exp_tms.push_back(1);
        exp_tms.push_back(0);
        exp_tms.push_back(1); exp_tms.push_back(1); exp_tms.push_back(0); exp_tms.push_back(0);
        for (int i = 0; i < IRL - 1; i++) exp_tms.push_back(0);
        exp_tms.push_back(1); exp_tms.push_back(1);
        exp_tms.push_back(0); exp_tms.push_back(1); exp_tms.push_back(0); exp_tms.push_back(0);
        for (int i = 0; i < 31; i++) exp_tms.push_back(0);
        exp_tms.push_back(1); exp_tms.push_back(1); exp_tms.push_back(0);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!busy && !done && !tck && !id_err, "R1 flags", {busy, done, tck, id_err}, 32'h0);
        chk(tms && tdi, "R1 tms/tdi", {tms, tdi}, 32'h3);
        chk(id == 32'h0, "R1 id", id, 32'h0);

        run_read(0, 1'b1, DEV_ID, 1'b0);     // R7 R10
        run_read(1, 1'b0, 32'hffff_ffff, 1'b1); // R9
        run_read(2, 1'b0, 32'h0, 1'b1);      // R9
        run_read(0, 1'b0, DEV_ID, 1'b0);     // R9 clears

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule